// File: doc/BRIEF.md
# Selectable Comma Framer

This block finds character boundaries in a received 10-bit line-coded stream. Each clock it takes one raw 10-bit word from a deserializer that has no knowledge of character alignment. It joins that word to the word before it to form a 20-bit window. In that window it looks for a framing pattern at every one of the ten possible bit offsets. Once a framing pattern is accepted, the offset where it was found becomes the character boundary. The block then emits properly aligned 10-bit characters, one per clock, until another alignment event moves the boundary.

Three static configuration inputs shape the search. The first chooses the pattern: either the 7-bit comma fragment in both disparities, or the complete K28.5 character in both disparities. The second chooses the alignment policy: single-event, where one detection realigns, or multi-event, where two detections at the same new offset are needed, spaced one or two characters apart. The third chooses low latency, which applies a newly accepted offset to the framing character itself instead of starting with the character after it. A framed flag reports that alignment has been reached. A one-cycle pulse marks every move of the boundary.

Top module: `comma_framer`

## Requirements
- R1: Bit 9 of each input word is the earliest bit received. Each cycle the search window is the previous word followed by the current word. Offset k (0 to 9) names the 10-bit character that starts k bits after the first bit of the previous word. All ten offsets are examined every cycle.
- R2: With fullCharSel low, an offset matches when the first 7 bits of its character are 0011111 or 1100000. The last three bits are ignored, so a K28.1 (0011111001) also frames.
- R3: With fullCharSel high, an offset matches only on the full character 0011111010 or 1100000101. A K28.1 then leaves framed low and the output invalid.
- R4: In single-event mode (multiMode low), one match at an offset other than the current one realigns the block to that offset. Before the block is framed, a match at any offset is accepted and sets framed.
- R5: In multi-event mode, a first match only records a candidate offset and leaves framed low. A second match at the same offset, with exactly one or two non-matching characters between the two, realigns and sets framed.
- R6: In multi-event mode, the candidate count starts over when two matches are adjacent, when three or more characters lie between them, or when a match appears at a different offset.
- R7: With lowLatency high, the character output on the edge that accepts an alignment is already cut at the new offset. With it low, that character is cut at the old offset, and the new offset applies from the next character on.
- R8: boundaryChg is high for exactly the one output character whose accepted offset differs from the previous offset, and charValid is low for that character. Accepting the offset already in use produces no pulse.
- R9: After reset the offset is 0, and framed, charValid and boundaryChg are low. Until the block is framed, output characters are cut at offset 0.
- R10: charOut is registered. It reflects the window of the cycle in which the word was presented and appears after that cycle's clock edge. charValid is high only while framed is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wordIn | input | 10 | Raw unaligned word, bit 9 received first |
| fullCharSel | input | 1 | 0: 7-bit comma fragment, 1: full K28.5 |
| multiMode | input | 1 | 0: single-event alignment, 1: two-event alignment |
| lowLatency | input | 1 | Apply a new offset to the framing character itself |
| charOut | output | 10 | Aligned character |
| charValid | output | 1 | charOut is an aligned character of a framed stream |
| framed | output | 1 | An alignment has been accepted since reset |
| boundaryChg | output | 1 | One-cycle pulse when the boundary moved |

## Verification
Some properties are checked on every cycle. framed never rises and the boundary never moves without a detection in the preceding window. In multi-event mode, framed rises only after a detection that followed a cycle with none. In single-event low-latency mode, the first detection steers the output slice to the detected offset. charValid never appears without framed. Other behaviours need the bench's stream scenarios: which of the two pattern choices frames on a K28.1, that data is cut at the correct bit offset, that adjacent commas or commas three characters apart restart the count, and in which output cycle the new alignment first takes effect.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int CHAR_W  = 10;
  localparam int WIN_W   = 2 * CHAR_W;
  localparam int OFF_W   = $clog2(CHAR_W);
  localparam int FRAG_W  = 7;
  localparam int GAP_MIN = 1;
  localparam int GAP_MAX = 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 2);

  localparam logic [FRAG_W-1:0] FRAG_NEG = 7'b0011111;
  localparam logic [FRAG_W-1:0] FRAG_POS = 7'b1100000;
  localparam logic [CHAR_W-1:0] FULL_NEG = 10'b0011111010;
  localparam logic [CHAR_W-1:0] FULL_POS = 10'b1100000101;

  // strobes from control to datapath
  typedef struct packed {
    logic             emit;      // stream is framed for this character
    logic             hold;      // boundary moves on this character
    logic [OFF_W-1:0] sliceOff;  // offset used to cut this character
  } alignCmd_t;
endpackage

// File: rtl/cfr_datapath.sv
module cfr_datapath
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] wordIn,
  input  logic              fullCharSel,
  input  alignCmd_t         cmd,
  output logic              hitAny,
  output logic [OFF_W-1:0]  hitOff,
  output logic [CHAR_W-1:0] charOut,
  output logic              charValid
);
  logic [CHAR_W-1:0] prevWord;
  logic [WIN_W-1:0]  window;
  logic [CHAR_W-1:0] hitVec;
  logic [CHAR_W-1:0] sliceArr [CHAR_W];
  logic [CHAR_W-1:0] selChar;

  assign window = {prevWord, wordIn};

  for (genvar k = 0; k < CHAR_W; k++) begin : g_offset
    logic fragMatch, fullMatch;
    assign sliceArr[k] = window[WIN_W-1-k -: CHAR_W];
    assign fragMatch   = (sliceArr[k][CHAR_W-1 -: FRAG_W] == FRAG_NEG) ||
                         (sliceArr[k][CHAR_W-1 -: FRAG_W] == FRAG_POS);
    assign fullMatch   = (sliceArr[k] == FULL_NEG) || (sliceArr[k] == FULL_POS);
    assign hitVec[k]   = fullCharSel ? fullMatch : fragMatch;
  end

  // lowest matching offset wins
  always_comb begin
    hitOff = '0;
    for (int k = CHAR_W - 1; k >= 0; k--) begin
      if (hitVec[k]) hitOff = OFF_W'(k);
    end
    hitAny = |hitVec;
  end

  always_comb begin
    selChar = sliceArr[0];
    for (int k = 0; k < CHAR_W; k++) begin
      if (cmd.sliceOff == OFF_W'(k)) selChar = sliceArr[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevWord  <= '0;
      charOut   <= '0;
      charValid <= 1'b0;
    end else begin
      prevWord  <= wordIn;
      charOut   <= selChar;
      charValid <= cmd.emit && !cmd.hold;
    end
  end
endmodule

// File: rtl/cfr_control.sv
module cfr_control
  import cfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             multiMode,
  input  logic             lowLatency,
  input  logic             hitAny,
  input  logic [OFF_W-1:0] hitOff,
  output alignCmd_t        cmd,
  output logic             framed,
  output logic             boundaryChg
);
  logic [OFF_W-1:0] curOff, candOff;
  logic             candValid;
  logic [GAP_W-1:0] gapCnt;
  logic             onCurrent, gapOk, accept, moved;

  always_comb begin
    onCurrent = framed && (hitOff == curOff);
    gapOk     = candValid && (candOff == hitOff) &&
                (gapCnt >= GAP_W'(GAP_MIN)) && (gapCnt <= GAP_W'(GAP_MAX));
    if (!hitAny)        accept = 1'b0;
    else if (multiMode) accept = !onCurrent && gapOk;
    else                accept = !onCurrent;
    moved        = accept && (hitOff != curOff);
    cmd.emit     = framed || accept;
    cmd.hold     = moved;
    cmd.sliceOff = (accept && lowLatency) ? hitOff : curOff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curOff      <= '0;
      framed      <= 1'b0;
      boundaryChg <= 1'b0;
    end else begin
      if (accept) curOff <= hitOff;
      framed      <= framed || accept;
      boundaryChg <= moved;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      candValid <= 1'b0;
      candOff   <= '0;
      gapCnt    <= '0;
    end else if (!multiMode || accept || (hitAny && onCurrent)) begin
      candValid <= 1'b0;
      gapCnt    <= '0;
    end else if (hitAny) begin
      candValid <= 1'b1;
      candOff   <= hitOff;
      gapCnt    <= '0;
    end else if (candValid && (gapCnt != '1)) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end
endmodule

// File: rtl/comma_framer.sv
module comma_framer
  import cfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CHAR_W-1:0] wordIn,
  input  logic              fullCharSel,
  input  logic              multiMode,
  input  logic              lowLatency,
  output logic [CHAR_W-1:0] charOut,
  output logic              charValid,
  output logic              framed,
  output logic              boundaryChg
);
  alignCmd_t        cmd;
  logic             hitAny;
  logic [OFF_W-1:0] hitOff;

  cfr_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .wordIn(wordIn), .fullCharSel(fullCharSel),
    .cmd(cmd), .hitAny(hitAny), .hitOff(hitOff),
    .charOut(charOut), .charValid(charValid)
  );

  cfr_control u_ctl (
    .clk(clk), .rst_n(rst_n), .multiMode(multiMode), .lowLatency(lowLatency),
    .hitAny(hitAny), .hitOff(hitOff), .cmd(cmd),
    .framed(framed), .boundaryChg(boundaryChg)
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker
  import cfr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             multiMode,
  input logic             lowLatency,
  input logic             hitAny,
  input logic [OFF_W-1:0] hitOff,
  input logic [OFF_W-1:0] sliceOff,
  input logic             framed,
  input logic             boundaryChg,
  input logic             charValid
);
  p_frame_needs_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(framed) |-> $past(hitAny));

  p_chg_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boundaryChg |-> $past(hitAny));

  p_multi_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (multiMode && $rose(framed)) |-> ($past(hitAny) && !$past(hitAny, 2)));

  p_lowlat_slice_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lowLatency && !multiMode && hitAny && !framed) |-> (sliceOff == hitOff));

  p_valid_needs_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    charValid |-> framed);
endmodule

bind comma_framer cfr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .multiMode(multiMode), .lowLatency(lowLatency),
  .hitAny(hitAny), .hitOff(hitOff), .sliceOff(cmd.sliceOff),
  .framed(framed), .boundaryChg(boundaryChg), .charValid(charValid)
);

// File: tb/comma_framer_test.sv
`timescale 1ns/1ps
module comma_framer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] wordIn = '0;
  logic       fullCharSel = 1'b0, multiMode = 1'b0, lowLatency = 1'b0;
  logic [9:0] charOut;
  logic       charValid, framed, boundaryChg;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  comma_framer uut (
    .clk(clk), .rst_n(rst_n), .wordIn(wordIn), .fullCharSel(fullCharSel),
    .multiMode(multiMode), .lowLatency(lowLatency), .charOut(charOut),
    .charValid(charValid), .framed(framed), .boundaryChg(boundaryChg)
  );

  localparam logic [9:0] K_NEG  = 10'b0011111010;
  localparam logic [9:0] K_POS  = 10'b1100000101;
  localparam logic [9:0] K281   = 10'b0011111001;

  // {multi, full, lowLat, shift[3:0], ctype[1:0], expFrame}
  localparam logic [9:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 4'd0, 2'd0, 1'b1},
    {1'b0, 1'b0, 1'b1, 4'd3, 2'd1, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'd7, 2'd0, 1'b1},
    {1'b0, 1'b1, 1'b0, 4'd5, 2'd2, 1'b0},
    {1'b0, 1'b0, 1'b1, 4'd9, 2'd2, 1'b1},
    {1'b1, 1'b0, 1'b0, 4'd4, 2'd0, 1'b1},
    {1'b1, 1'b1, 1'b1, 4'd6, 2'd1, 1'b1},
    {1'b1, 1'b0, 1'b1, 4'd0, 2'd0, 1'b1}
  };

  logic       sb [0:511];
  int         sLen;
  logic       tog;
  logic [9:0] recChar [0:31];
  logic       recV [0:31];
  logic       recF [0:31];
  logic       recC [0:31];

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] dataChar(input int i);
    case (i % 4)
      0: return 10'b1010101010;
      1: return 10'b0101010101;
      2: return 10'b1010100101;
      default: return 10'b0101011010;
    endcase
  endfunction

  task automatic clearStream();
    sLen = 0;
    tog  = 1'b1;
  endtask

  task automatic addBits(input int n);
    for (int i = 0; i < n; i++) begin
      sb[sLen] = tog;
      tog = ~tog;
      sLen++;
    end
  endtask

  task automatic addChar(input logic [9:0] c);
    for (int i = 9; i >= 0; i--) begin
      sb[sLen] = c[i];
      sLen++;
    end
  endtask

  function automatic logic [9:0] sliceAt(input int p);
    logic [9:0] r;
    for (int i = 0; i < 10; i++) r[9-i] = sb[p+i];
    return r;
  endfunction

  task automatic doReset(input logic m, input logic f, input logic l);
    @(negedge clk);
    rst_n = 1'b0;
    wordIn = '0;
    multiMode = m;
    fullCharSel = f;
    lowLatency = l;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check(!framed && !charValid && !boundaryChg && charOut == 10'd0, "R9",
          "reset state", {charOut, framed, charValid, boundaryChg}, 0);
  endtask

  task automatic feed(input int n);
    for (int t = 0; t < n; t++) begin
      wordIn = sliceAt(10 * t);
      @(posedge clk);
      @(negedge clk);
      recChar[t] = charOut;
      recV[t] = charValid;
      recF[t] = framed;
      recC[t] = boundaryChg;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // table walk
    for (int e = 0; e < 8; e++) begin
      logic m, f, l, x;
      int s, T;
      logic [9:0] k;
      {m, f, l} = VEC[e][9:7];
      s = int'(VEC[e][6:3]);
      x = VEC[e][0];
      k = (VEC[e][2:1] == 2'd0) ? K_NEG : (VEC[e][2:1] == 2'd1) ? K_POS : K281;
      doReset(m, f, l);
      clearStream();
      addBits(s);
      for (int c = 0; c < 18; c++) addChar((c == 3 || c == 6) ? k : dataChar(c));
      feed(18);
      T = m ? 7 : 4;
      check(recF[T-1] == 1'b0, m ? "R5" : "R4", "framed before event", recF[T-1], 0);
      if (m) check(recF[4] == 1'b0, "R5", "first detection only", recF[4], 0);
      check(recF[T] == x, f ? "R3" : "R2", "framed on pattern", recF[T], x);
      if (x) begin
        check(recC[T] == (s != 0), "R8", "pulse on move", recC[T], s != 0);
        check(recV[T] == (s == 0), "R8", "valid on move", recV[T], s == 0);
        if (l)
          check(recChar[T] == sliceAt(10*(T-1) + s), "R7", "low latency char",
                recChar[T], sliceAt(10*(T-1) + s));
        else
          check(recChar[T] == sliceAt(10*(T-1)), "R7", "old offset char",
                recChar[T], sliceAt(10*(T-1)));
        check(recC[T+1] == 1'b0, "R8", "pulse one cycle", recC[T+1], 0);
        check(recChar[T+2] == sliceAt(10*(T+1) + s) && recV[T+2], "R1",
              "aligned data", recChar[T+2], sliceAt(10*(T+1) + s));
        if (!m) check(recC[7] == 1'b0, "R8", "no pulse same offset", recC[7], 0);
      end else begin
        check(recF[T+2] == 1'b0 && recV[T+2] == 1'b0, "R3", "K28.1 ignored",
              {recF[T+2], recV[T+2]}, 0);
      end
    end

    // multi mode: adjacent and wide spacing restart
    doReset(1'b1, 1'b0, 1'b0);
    clearStream();
    addBits(2);
    for (int c = 0; c < 18; c++)
      addChar((c == 1 || c == 2 || c == 6 || c == 9) ? K_NEG : dataChar(c));
    feed(18);
    check(recF[3] == 1'b0, "R6", "adjacent commas", recF[3], 0);
    check(recF[9] == 1'b0, "R6", "three between", recF[9], 0);
    check(recF[10] == 1'b1 && recC[10] == 1'b1, "R5", "two between frames",
          {recF[10], recC[10]}, 3);
    check(recChar[11] == sliceAt(10*10 + 2), "R1", "data after multi frame",
          recChar[11], sliceAt(10*10 + 2));

    // multi mode: offset change restarts
    doReset(1'b1, 1'b0, 1'b0);
    clearStream();
    addBits(1);
    addChar(dataChar(0));
    addChar(K_POS);
    addChar(dataChar(1));
    addBits(2);
    addChar(K_POS);
    addChar(dataChar(2));
    addChar(K_POS);
    for (int c = 0; c < 13; c++) addChar(dataChar(c));
    feed(18);
    check(recF[4] == 1'b0 && recF[5] == 1'b0, "R6", "offset change restarts",
          {recF[4], recF[5]}, 0);
    check(recF[6] == 1'b1 && recC[6] == 1'b1 && !recV[6], "R6", "frame at new offset",
          {recF[6], recC[6], recV[6]}, 6);
    check(recChar[7] == sliceAt(63) && recV[7], "R7", "next char aligned",
          recChar[7], sliceAt(63));

    // single mode: initial offset 0 and later realign
    doReset(1'b0, 1'b0, 1'b0);
    clearStream();
    addChar(dataChar(0));
    addChar(K_NEG);
    addChar(dataChar(1));
    addChar(dataChar(2));
    addBits(5);
    addChar(K_NEG);
    for (int c = 0; c < 14; c++) addChar(dataChar(c + 1));
    feed(18);
    check(recChar[0] == 10'd0 && recChar[1] == sliceAt(0) && !recV[1], "R9",
          "unframed offset 0", recChar[1], sliceAt(0));
    check(recF[2] && !recC[2] && recV[2] && recChar[2] == K_NEG, "R8",
          "frame at offset 0 no pulse", {recF[2], recC[2], recV[2]}, 5);
    check(recC[5] && !recV[5], "R4", "single realign", {recC[5], recV[5]}, 2);
    check(recChar[6] == sliceAt(55) && recV[6], "R10", "registered aligned char",
          recChar[6], sliceAt(55));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule